// File: doc/BRIEF.md
# Event-Triggered Delay Timer Channel

This block is one channel of a delay timer. A 32-bit down-counter starts on a trigger strobe. It counts microsecond tick strobes and raises an output pulse when the programmed delay has run out. The block does not match events, generate clocks or queue commands. The trigger and the tick arrive already decoded, each as a strobe one clock cycle wide.

A delay setting arrives as two 16-bit word writes. Each write carries a mode flag, normal or sync. A completed setting lands in a shadow register, called the last-written value, and from there it moves into the running register that arms the counter. A normal setting moves across as soon as the channel is not counting. A sync setting moves across only on the cycle after a count ends. A load never disturbs a count that is in progress. While a setting waits, a pending flag is raised, and a newer setting replaces the one that is waiting. Inhibit stops the channel at once, even mid-count. Enable re-arms it with the running value.

All inputs are single-cycle strobes. Every write is accepted in the cycle it appears, so the block exerts no back-pressure and has no ready signal.

Top module: `delay_timer_chan`

## Requirements
- R1: After reset, run_val and last_val read 0, status bits 0, 2 and 3 read 0 (channel inhibited, nothing pending), and out_pulse is low.
- R2: A setting counts only when a low-word write (wr_lo) is followed, with no high-word write in between, by a high-word write (wr_hi) carrying the same wr_sync value. The high write supplies bits 31:16 and the most recent low write supplies bits 15:0. A lone high write, a mode mismatch, or a second high write after a completed pair leaves last_val unchanged.
- R3: A normal-mode setting (wr_sync=0) that completes while the channel is not counting updates both run_val and last_val on the clock edge that captures the high write.
- R4: A normal-mode setting that completes while the channel is counting updates last_val only. It raises status bit 2. It then loads into run_val on the edge after the count ends, and that load clears bit 2. While the channel is counting, run_val never changes.
- R5: A sync-mode setting (wr_sync=1) always goes pending, even when the channel is idle. It loads only on the edge after a counting-to-idle transition. Status bit 3 reads 1 while a sync setting is pending and the channel is not counting.
- R6: When several settings complete while one is pending, the newest one is the one that loads.
- R7: After a trigger, out_pulse rises on the edge that captures the N-th tick, where N is run_val. A run_val of 0 or 1 behaves as 2.
- R8: A trigger while counting neither restarts nor reloads the count. A trigger while inhibited is ignored.
- R9: inhibit_cmd aborts a count and clears out_pulse on the next edge and makes the channel inhibited. enable_cmd on an inhibited channel arms it, and the next trigger starts a count from run_val.
- R10: out_pulse stays high from the timeout tick until the next tick, which lowers it.
- R11: status bit 0 = enabled, bit 1 = clk_present input, bit 2 = setting pending, bit 3 = sync setting pending with the channel idle.
- R12: Whenever status bit 2 is 0, run_val equals last_val.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe per microsecond |
| trigger | input | 1 | One-cycle trigger strobe |
| enable_cmd | input | 1 | Arm an inhibited channel |
| inhibit_cmd | input | 1 | Abort and inhibit the channel |
| wr_lo | input | 1 | Low-word setting write |
| wr_hi | input | 1 | High-word setting write |
| wr_sync | input | 1 | Mode of the write: 0 normal, 1 sync |
| wr_data | input | 16 | Word being written |
| clk_present | input | 1 | Clock-present indication, shown in status |
| out_pulse | output | 1 | Timeout pulse |
| run_val | output | 32 | Running delay value |
| last_val | output | 32 | Last written delay value |
| status | output | 4 | Status nibble |

## Verification
The bench drives malformed word sequences: a lone high word, mixed modes, a repeated low word, and a repeated high word. A design that paired words too loosely would then show a changed last_val. It writes settings mid-count, once and then twice. A design that loaded early would shorten the count under way, and one that kept the older setting would show the wrong run_val after the count ends. A sync setting is left idle for several cycles to catch a design that loads it like a normal one. Retriggers mid-count, delays of 0 and 1, and an inhibit during a count and during a pulse expose restarts, off-by-one tick counts, and aborts that do not take effect at once.

// File: rtl/dtc_pkg.sv
`timescale 1ns/1ps
package dtc_pkg;
  typedef enum logic [1:0] {
    CH_OFF   = 2'd0,
    CH_ARMED = 2'd1,
    CH_COUNT = 2'd2
  } ch_state_e;

  localparam int unsigned STAT_W = 4;
endpackage

// File: rtl/dtc_word_pair.sv
`timescale 1ns/1ps
// Pairs a low word with the following high word of the same mode.
module dtc_word_pair #(
  parameter int unsigned HALF_W = 16,
  localparam int unsigned VAL_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_sync,
  input  logic [HALF_W-1:0] wr_data,
  output logic              set_valid,
  output logic [VAL_W-1:0]  set_value,
  output logic              set_sync
);
  logic [HALF_W-1:0] lo_hold_q;
  logic              lo_sync_q;
  logic              lo_ok_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_hold_q <= '0;
      lo_sync_q <= 1'b0;
      lo_ok_q   <= 1'b0;
    end else begin
      if (wr_hi) lo_ok_q <= 1'b0;
      if (wr_lo) begin
        lo_hold_q <= wr_data;
        lo_sync_q <= wr_sync;
        lo_ok_q   <= 1'b1;
      end
    end
  end

  always_comb begin
    set_valid = wr_hi && lo_ok_q && (lo_sync_q == wr_sync);
    set_value = {wr_data, lo_hold_q};
    set_sync  = wr_sync;
  end
endmodule

// File: rtl/dtc_shadow_load.sv
`timescale 1ns/1ps
// Shadow register, pending flag and the two load policies.
module dtc_shadow_load #(
  parameter int unsigned VAL_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_valid,
  input  logic [VAL_W-1:0] set_value,
  input  logic             set_sync,
  input  logic             busy,
  output logic [VAL_W-1:0] run_val,
  output logic [VAL_W-1:0] shadow_val,
  output logic             pending,
  output logic             pend_sync
);
  logic busy_q;
  logic busy_fell;
  logic load_now;

  assign busy_fell = busy_q && !busy;
  assign load_now  = pending && (pend_sync ? busy_fell : !busy);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      run_val    <= '0;
      shadow_val <= '0;
      pending    <= 1'b0;
      pend_sync  <= 1'b0;
    end else begin
      busy_q <= busy;
      if (set_valid) begin
        shadow_val <= set_value;
        pend_sync  <= set_sync;
        if (!set_sync && !busy) begin
          run_val <= set_value;
          pending <= 1'b0;
        end else begin
          pending <= 1'b1;
        end
      end else if (load_now) begin
        run_val <= shadow_val;
        pending <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dtc_delay_core.sv
`timescale 1ns/1ps
// Down-counter, arm/abort control and timeout pulse.
module dtc_delay_core
  import dtc_pkg::*;
#(
  parameter int unsigned VAL_W     = 32,
  parameter int unsigned MIN_DELAY = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             trigger,
  input  logic             enable_cmd,
  input  logic             inhibit_cmd,
  input  logic [VAL_W-1:0] run_val,
  output logic             busy,
  output logic             enabled,
  output logic             out_pulse,
  output logic [VAL_W-1:0] cnt_q
);
  localparam logic [VAL_W-1:0] MIN_V = VAL_W'(MIN_DELAY);

  ch_state_e        state_q;
  logic [VAL_W-1:0] start_v;

  assign start_v = (run_val < MIN_V) ? MIN_V : run_val;
  assign busy    = (state_q == CH_COUNT);
  assign enabled = (state_q != CH_OFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= CH_OFF;
      cnt_q     <= '0;
      out_pulse <= 1'b0;
    end else if (inhibit_cmd) begin
      state_q   <= CH_OFF;
      out_pulse <= 1'b0;
    end else begin
      if (tick) out_pulse <= 1'b0;
      unique case (state_q)
        CH_OFF: begin
          if (enable_cmd) state_q <= CH_ARMED;
        end
        CH_ARMED: begin
          if (trigger) begin
            cnt_q   <= start_v;
            state_q <= CH_COUNT;
          end
        end
        CH_COUNT: begin
          if (tick) begin
            if (cnt_q <= VAL_W'(1)) begin
              state_q   <= CH_ARMED;
              out_pulse <= 1'b1;
            end else begin
              cnt_q <= cnt_q - VAL_W'(1);
            end
          end
        end
        default: state_q <= CH_OFF;
      endcase
    end
  end
endmodule

// File: rtl/delay_timer_chan.sv
`timescale 1ns/1ps
module delay_timer_chan
  import dtc_pkg::*;
#(
  parameter int unsigned HALF_W    = 16,
  parameter int unsigned MIN_DELAY = 2,
  localparam int unsigned VAL_W    = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              trigger,
  input  logic              enable_cmd,
  input  logic              inhibit_cmd,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_sync,
  input  logic [HALF_W-1:0] wr_data,
  input  logic              clk_present,
  output logic              out_pulse,
  output logic [VAL_W-1:0]  run_val,
  output logic [VAL_W-1:0]  last_val,
  output logic [STAT_W-1:0] status
);
  logic             set_valid;
  logic [VAL_W-1:0] set_value;
  logic             set_sync;
  logic             busy;
  logic             enabled;
  logic             pending;
  logic             pend_sync;
  logic [VAL_W-1:0] cnt_q;

  dtc_word_pair #(.HALF_W(HALF_W)) pair_i (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wr_sync(wr_sync), .wr_data(wr_data),
    .set_valid(set_valid), .set_value(set_value), .set_sync(set_sync)
  );

  dtc_shadow_load #(.VAL_W(VAL_W)) shadow_i (
    .clk(clk), .rst_n(rst_n), .set_valid(set_valid), .set_value(set_value),
    .set_sync(set_sync), .busy(busy), .run_val(run_val),
    .shadow_val(last_val), .pending(pending), .pend_sync(pend_sync)
  );

  dtc_delay_core #(.VAL_W(VAL_W), .MIN_DELAY(MIN_DELAY)) core_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .trigger(trigger),
    .enable_cmd(enable_cmd), .inhibit_cmd(inhibit_cmd), .run_val(run_val),
    .busy(busy), .enabled(enabled), .out_pulse(out_pulse), .cnt_q(cnt_q)
  );

  assign status = {pending && pend_sync && !busy, pending, clk_present, enabled};
endmodule

// File: rtl/dtc_checker.sv
`timescale 1ns/1ps
module dtc_checker #(
  parameter int unsigned VAL_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             inhibit_cmd,
  input logic             busy,
  input logic             out_pulse,
  input logic [VAL_W-1:0] cnt_q,
  input logic [VAL_W-1:0] run_val,
  input logic [VAL_W-1:0] last_val,
  input logic [3:0]       status
);
  p_run_held_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(run_val));

  p_sync_idle_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    status[3] |-> (status[2] && !busy));

  p_no_retrigger_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick && !inhibit_cmd) |=> $stable(cnt_q));

  p_inhibit_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit_cmd |=> (!busy && !out_pulse && !status[0]));

  p_pulse_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_pulse && !tick && !inhibit_cmd) |=> out_pulse);

  p_pulse_origin_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_pulse) |-> ($past(busy) && $past(tick)));

  p_values_agree_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !status[2] |-> (run_val == last_val));
endmodule

bind delay_timer_chan dtc_checker #(.VAL_W(2 * HALF_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .inhibit_cmd(inhibit_cmd),
  .busy(busy), .out_pulse(out_pulse), .cnt_q(cnt_q), .run_val(run_val),
  .last_val(last_val), .status(status)
);

// File: tb/delay_timer_chan_tb_top.sv
`timescale 1ns/1ps
module delay_timer_chan_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, trigger = 1'b0, enable_cmd = 1'b0, inhibit_cmd = 1'b0;
  logic        wr_lo = 1'b0, wr_hi = 1'b0, wr_sync = 1'b0;
  logic [15:0] wr_data = '0;
  logic        clk_present = 1'b1;
  logic        out_pulse;
  logic [31:0] run_val, last_val;
  logic [3:0]  status;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  delay_timer_chan dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .trigger(trigger),
    .enable_cmd(enable_cmd), .inhibit_cmd(inhibit_cmd), .wr_lo(wr_lo),
    .wr_hi(wr_hi), .wr_sync(wr_sync), .wr_data(wr_data),
    .clk_present(clk_present), .out_pulse(out_pulse), .run_val(run_val),
    .last_val(last_val), .status(status)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; step(); tick = 1'b0;
    end
  endtask

  task automatic wr_word(bit hi, logic [15:0] d, logic s);
    wr_lo = !hi; wr_hi = hi; wr_sync = s; wr_data = d;
    step();
    wr_lo = 1'b0; wr_hi = 1'b0; wr_sync = 1'b0;
  endtask

  task automatic wr_set(logic [31:0] v, logic s);
    wr_word(1'b0, v[15:0], s);
    wr_word(1'b1, v[31:16], s);
  endtask

  task automatic fire();
    trigger = 1'b1; step(); trigger = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "run_val", run_val, 32'h0);
    check("R1", "last_val", last_val, 32'h0);
    check("R1", "status", {28'h0, status}, 32'h2);
    check("R1", "out_pulse", {31'h0, out_pulse}, 32'h0);
    check("R11", "clk_present bit", {31'h0, status[1]}, 32'h1);
  endtask

  task automatic t_pairing();
    wr_set(32'h0000_0005, 1'b0);
    check("R3", "run after idle write", run_val, 32'h5);
    check("R3", "last after idle write", last_val, 32'h5);
    wr_word(1'b1, 16'h00AA, 1'b0);
    check("R2", "lone high word", last_val, 32'h5);
    wr_word(1'b0, 16'h0077, 1'b0);
    wr_word(1'b1, 16'h0000, 1'b1);
    check("R2", "mode mismatch", last_val, 32'h5);
    wr_word(1'b0, 16'h0011, 1'b0);
    wr_word(1'b0, 16'h0022, 1'b0);
    wr_word(1'b1, 16'h0001, 1'b0);
    check("R2", "newest low word", last_val, 32'h0001_0022);
    check("R3", "run follows", run_val, 32'h0001_0022);
    wr_word(1'b1, 16'h0003, 1'b0);
    check("R2", "repeat high word", last_val, 32'h0001_0022);
  endtask

  task automatic t_delay();
    wr_set(32'd5, 1'b0);
    enable_cmd = 1'b1; step(); enable_cmd = 1'b0;
    check("R11", "enabled bit", {31'h0, status[0]}, 32'h1);
    fire();
    ticks(4);
    check("R7", "no pulse before tick 5", {31'h0, out_pulse}, 32'h0);
    ticks(1);
    check("R7", "pulse at tick 5", {31'h0, out_pulse}, 32'h1);
    step(); step(); step();
    check("R10", "pulse held between ticks", {31'h0, out_pulse}, 32'h1);
    ticks(1);
    check("R10", "pulse drops on next tick", {31'h0, out_pulse}, 32'h0);
    wr_set(32'd0, 1'b0);
    fire(); ticks(1);
    check("R7", "value 0 not yet", {31'h0, out_pulse}, 32'h0);
    ticks(1);
    check("R7", "value 0 gives 2 ticks", {31'h0, out_pulse}, 32'h1);
    ticks(1);
    wr_set(32'd1, 1'b0);
    fire(); ticks(1);
    check("R7", "value 1 not yet", {31'h0, out_pulse}, 32'h0);
    ticks(1);
    check("R7", "value 1 gives 2 ticks", {31'h0, out_pulse}, 32'h1);
    ticks(1);
  endtask

  task automatic t_retrigger();
    wr_set(32'd4, 1'b0);
    fire(); ticks(2);
    fire(); ticks(1);
    check("R8", "no pulse at tick 3", {31'h0, out_pulse}, 32'h0);
    ticks(1);
    check("R8", "retrigger ignored, pulse at tick 4", {31'h0, out_pulse}, 32'h1);
    ticks(1);
  endtask

  task automatic t_pending();
    wr_set(32'd10, 1'b0);
    fire(); ticks(2);
    wr_set(32'd7, 1'b0);
    check("R4", "pending bit", {31'h0, status[2]}, 32'h1);
    check("R4", "run held", run_val, 32'd10);
    check("R4", "last updated", last_val, 32'd7);
    wr_set(32'd9, 1'b0);
    check("R6", "newest last", last_val, 32'd9);
    ticks(7);
    check("R4", "no pulse at tick 9", {31'h0, out_pulse}, 32'h0);
    ticks(1);
    check("R4", "old delay runs out", {31'h0, out_pulse}, 32'h1);
    step();
    check("R6", "newest loaded", run_val, 32'd9);
    check("R4", "pending cleared", {31'h0, status[2]}, 32'h0);
    check("R12", "run equals last", run_val, last_val);
    ticks(1);
  endtask

  task automatic t_sync();
    wr_set(32'd3, 1'b1);
    check("R5", "sync pending when idle", {28'h0, status}, 32'hF);
    step(); step(); step(); step(); step();
    check("R5", "sync waits while idle", run_val, 32'd9);
    fire();
    check("R5", "bit3 low while busy", {31'h0, status[3]}, 32'h0);
    ticks(8);
    check("R5", "no pulse at tick 8", {31'h0, out_pulse}, 32'h0);
    ticks(1);
    check("R5", "old value used", {31'h0, out_pulse}, 32'h1);
    step();
    check("R5", "loaded after busy end", run_val, 32'd3);
    check("R11", "status after load", {28'h0, status}, 32'h3);
    ticks(1);
  endtask

  task automatic t_inhibit();
    wr_set(32'd6, 1'b0);
    fire(); ticks(2);
    inhibit_cmd = 1'b1; step(); inhibit_cmd = 1'b0;
    check("R9", "inhibited", {31'h0, status[0]}, 32'h0);
    ticks(10);
    check("R9", "aborted count gives no pulse", {31'h0, out_pulse}, 32'h0);
    fire();
    enable_cmd = 1'b1; step(); enable_cmd = 1'b0;
    ticks(10);
    check("R8", "trigger while inhibited ignored", {31'h0, out_pulse}, 32'h0);
    fire(); ticks(5);
    check("R9", "re-armed, no pulse at tick 5", {31'h0, out_pulse}, 32'h0);
    ticks(1);
    check("R9", "re-armed pulse at tick 6", {31'h0, out_pulse}, 32'h1);
    inhibit_cmd = 1'b1; step(); inhibit_cmd = 1'b0;
    check("R9", "inhibit clears pulse", {31'h0, out_pulse}, 32'h0);
  endtask

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_pairing();
    t_delay();
    t_retrigger();
    t_pending();
    t_sync();
    t_inhibit();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule